// File: doc/BRIEF.md
# Type-C Source Attach Controller

This block is the connection state machine of a source-only USB Type-C port. It receives, for each of the two configuration-channel pins, a digitised classification of the far-end termination: open, Ra or Rd. It also receives a flag that VBUS sits at vSafe0V, a VBUS-present flag, the single result of an external VBUS voltage-window check, and a group of fault flags. From these inputs it decides whether a sink, an audio accessory or a debug accessory is connected. It then drives the CC pull-up enables, the VCONN enables, the orientation output, the power-path enable, an attached-mode code and a state code.

A new CC pattern is acted on only after it has held unchanged for a debounce window. An attach is refused while VBUS has not reached vSafe0V. A fault moves the machine into a timed recovery state. That state drops the power path and removes the CC pull-ups for a fixed hold, and then returns to the unattached state. A detach produces a one-cycle pulse that downstream discharge logic can use.

Top module: `typec_src_attach`

## Requirements
- R1: While `rst` is high, `ccTermEn` is 2'b00. After reset the state code is 0 (Unattached), `ccTermEn` is 2'b11, and `attachMode`, `orientLow`, `vconnEn`, `pwrPathEn`, `debugFlag` and `detachPulse` are all 0.
- R2: Class codes are 0 open, 1 Ra, 2 Rd; code 3 counts as open. When one pin is Rd and the other is open or Ra, the state becomes 1 (Attached) with `attachMode` 1.
- R3: `orientLow` is 0 when the sink was found on CC1 and 1 when it was found on CC2. Its value stays constant for as long as the state remains Attached.
- R4: `vconnEn` is non-zero only in the Attached state. In that state it is set only on the pin opposite the sink: bit 1 (CC2) for a CC1 sink, bit 0 (CC1) for a CC2 sink.
- R5: Ra on both pins gives state 2 (AudioAccessory) with `attachMode` 2. In this state there is no power path and no VCONN, and a VBUS window fault has no effect.
- R6: Rd on both pins gives state 3 (UnorientedDebug) with `attachMode` 3 and `debugFlag` 1. A later stable pattern of one Rd and one Ra gives state 4 (OrientedDebug). In state 4, `orientLow` reflects the Rd pin.
- R7: An attach transition is taken only after the pin pattern has been unchanged for DEBOUNCE_TICKS clocks. Any change to the pattern restarts the wait.
- R8: No attach is taken while `vSafe0V` is low.
- R9: When the sink pin goes open in Attached or OrientedDebug, or either pin goes open in AudioAccessory or UnorientedDebug, the state becomes 0. In the same cycle `detachPulse` is high for exactly one clock.
- R10: Overtemperature, pull-up supply invalid, or CC overvoltage moves any state other than ErrorRecovery to state 5 (ErrorRecovery) on the next clock.
- R11: In states 1, 3 and 4 only, the following move the machine to state 5: VBUS present with the window flag low, `vddUnder` with `vddUnderChkEn` set, or `vddOver` with `vddOverChkEn` set. A VDD flag whose check-enable is clear has no effect.
- R12: In ErrorRecovery, `ccTermEn` is 2'b00 and `pwrPathEn` is 0. The state lasts exactly RECOVERY_TICKS clocks and then becomes 0.
- R13: `pwrPathEn` is 1 exactly in states 1, 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| cc1Class | input | 2 | CC1 termination class (0 open, 1 Ra, 2 Rd) |
| cc2Class | input | 2 | CC2 termination class (0 open, 1 Ra, 2 Rd) |
| vSafe0V | input | 1 | VBUS is at vSafe0V |
| vbusPresent | input | 1 | VBUS is present |
| vbusInRange | input | 1 | VBUS is inside the valid window |
| faultOverTemp | input | 1 | Overtemperature |
| faultPullupBad | input | 1 | CC pull-up supply invalid |
| faultCcOvp | input | 1 | CC overvoltage |
| vddUnder | input | 1 | VDD below undervoltage limit |
| vddOver | input | 1 | VDD above overvoltage limit |
| vddUnderChkEn | input | 1 | Enable VDD undervoltage check |
| vddOverChkEn | input | 1 | Enable VDD overvoltage check |
| ccTermEn | output | 2 | Pull-up enable per pin, bit 0 CC1 |
| vconnEn | output | 2 | VCONN enable per pin, bit 0 CC1 |
| orientLow | output | 1 | Orientation drive-low (1 means sink on CC2) |
| pwrPathEn | output | 1 | VBUS power-path enable |
| attachMode | output | 2 | 0 none, 1 sink, 2 audio, 3 debug |
| stateCode | output | 3 | Current state code |
| debugFlag | output | 1 | Debug accessory indication |
| detachPulse | output | 1 | One-cycle detach strobe |

## Verification
The bench builds the block with DEBOUNCE_TICKS set to 8 and RECOVERY_TICKS set to 20, in place of the real-time defaults of tens of thousands and millions of clocks. These short windows make the exact debounce boundary observable: the bench checks one sample before and one after the window. They also make the full recovery hold observable, including its first and last cycle and the immediate re-attach that follows it. Many attach, detach and fault sequences fit in a short run.

// File: rtl/typec_src_pkg.sv
package typec_src_pkg;
  localparam logic [1:0] CC_OPEN = 2'd0;
  localparam logic [1:0] CC_RA   = 2'd1;
  localparam logic [1:0] CC_RD   = 2'd2;
  localparam logic [1:0] CC_RSV  = 2'd3;

  typedef enum logic [2:0] {
    ST_UNATT    = 3'd0,
    ST_ATT      = 3'd1,
    ST_AUDIO    = 3'd2,
    ST_DBG_UNOR = 3'd3,
    ST_DBG_OR   = 3'd4,
    ST_RECOVER  = 3'd5
  } tcState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic recClear;
    logic recRun;
  } dpStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic ccStable;
    logic recDone;
  } dpStatus_t;
endpackage

// File: rtl/typec_src_dpath.sv
module typec_src_dpath
  import typec_src_pkg::*;
#(
  parameter int DEBOUNCE_TICKS = 37500,
  parameter int RECOVERY_TICKS = 6250000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cc1Class,
  input  logic [1:0] cc2Class,
  input  dpStrobe_t  dpStrobe,
  output dpStatus_t  dpStatus
);
  localparam int DW = $clog2(DEBOUNCE_TICKS + 1);
  localparam int RW = $clog2(RECOVERY_TICKS + 1);
  localparam logic [DW-1:0] DEB_LAST = DW'(DEBOUNCE_TICKS - 1);
  localparam logic [RW-1:0] REC_LAST = RW'(RECOVERY_TICKS - 1);

  logic [3:0]    ccPair, prevPair;
  logic [DW-1:0] debCnt;
  logic [RW-1:0] recCnt;

  assign ccPair = {cc1Class, cc2Class};

  // pattern stability counter: restarts on any change, saturates at the window end
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      prevPair <= '0;
      debCnt   <= '0;
    end else if (ccPair != prevPair) begin
      prevPair <= ccPair;
      debCnt   <= '0;
    end else if (debCnt != DEB_LAST) begin
      debCnt <= debCnt + 1'b1;
    end
  end

  // recovery hold timer
  always_ff @(posedge clk or posedge rst) begin
    if (rst)                recCnt <= '0;
    else if (dpStrobe.recClear) recCnt <= '0;
    else if (dpStrobe.recRun)   recCnt <= recCnt + 1'b1;
  end

  assign dpStatus.ccStable = (ccPair == prevPair) && (debCnt == DEB_LAST);
  assign dpStatus.recDone  = (recCnt == REC_LAST);
endmodule

// File: rtl/typec_src_ctrl.sv
module typec_src_ctrl
  import typec_src_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cc1Class,
  input  logic [1:0] cc2Class,
  input  dpStatus_t  dpStatus,
  input  logic       vSafe0V,
  input  logic       vbusPresent,
  input  logic       vbusInRange,
  input  logic       faultOverTemp,
  input  logic       faultPullupBad,
  input  logic       faultCcOvp,
  input  logic       vddUnder,
  input  logic       vddOver,
  input  logic       vddUnderChkEn,
  input  logic       vddOverChkEn,
  output tcState_t   state,
  output logic       orientLow,
  output logic       detachPulse,
  output dpStrobe_t  dpStrobe
);
  tcState_t   nextState;
  logic       nextOrient, detachNext;
  logic       globalFault, poweredFault, powered, canAttach;
  logic [1:0] sinkCls;

  function automatic logic isOpen(input logic [1:0] c);
    return (c == CC_OPEN) || (c == CC_RSV);
  endfunction

  assign globalFault  = faultOverTemp | faultPullupBad | faultCcOvp;
  assign poweredFault = (vbusPresent & ~vbusInRange) |
                        (vddUnder & vddUnderChkEn) |
                        (vddOver & vddOverChkEn);
  assign powered   = (state == ST_ATT) || (state == ST_DBG_UNOR) || (state == ST_DBG_OR);
  assign canAttach = dpStatus.ccStable && vSafe0V;
  assign sinkCls   = orientLow ? cc2Class : cc1Class;

  always_comb begin
    nextState  = state;
    nextOrient = orientLow;
    detachNext = 1'b0;
    if (state != ST_RECOVER && (globalFault || (powered && poweredFault))) begin
      nextState  = ST_RECOVER;
      nextOrient = 1'b0;
    end else begin
      case (state)
        ST_UNATT: if (canAttach) begin
          if (cc1Class == CC_RD && cc2Class == CC_RD) begin
            nextState = ST_DBG_UNOR;
          end else if (cc1Class == CC_RA && cc2Class == CC_RA) begin
            nextState = ST_AUDIO;
          end else if (cc1Class == CC_RD) begin
            nextState  = ST_ATT;
            nextOrient = 1'b0;
          end else if (cc2Class == CC_RD) begin
            nextState  = ST_ATT;
            nextOrient = 1'b1;
          end
        end
        ST_ATT, ST_DBG_OR: if (isOpen(sinkCls)) begin
          nextState  = ST_UNATT;
          nextOrient = 1'b0;
          detachNext = 1'b1;
        end
        ST_AUDIO: if (isOpen(cc1Class) || isOpen(cc2Class)) begin
          nextState  = ST_UNATT;
          detachNext = 1'b1;
        end
        ST_DBG_UNOR: begin
          if (isOpen(cc1Class) || isOpen(cc2Class)) begin
            nextState  = ST_UNATT;
            detachNext = 1'b1;
          end else if (dpStatus.ccStable && cc1Class == CC_RD && cc2Class == CC_RA) begin
            nextState  = ST_DBG_OR;
            nextOrient = 1'b0;
          end else if (dpStatus.ccStable && cc1Class == CC_RA && cc2Class == CC_RD) begin
            nextState  = ST_DBG_OR;
            nextOrient = 1'b1;
          end
        end
        ST_RECOVER: if (dpStatus.recDone) nextState = ST_UNATT;
        default: nextState = ST_UNATT;
      endcase
    end
  end

  always_comb begin
    dpStrobe.recClear = (nextState == ST_RECOVER) && (state != ST_RECOVER);
    dpStrobe.recRun   = (state == ST_RECOVER);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state       <= ST_UNATT;
      orientLow   <= 1'b0;
      detachPulse <= 1'b0;
    end else begin
      state       <= nextState;
      orientLow   <= nextOrient;
      detachPulse <= detachNext;
    end
  end
endmodule

// File: rtl/typec_src_attach.sv
module typec_src_attach
  import typec_src_pkg::*;
#(
  parameter int DEBOUNCE_TICKS = 37500,
  parameter int RECOVERY_TICKS = 6250000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cc1Class,
  input  logic [1:0] cc2Class,
  input  logic       vSafe0V,
  input  logic       vbusPresent,
  input  logic       vbusInRange,
  input  logic       faultOverTemp,
  input  logic       faultPullupBad,
  input  logic       faultCcOvp,
  input  logic       vddUnder,
  input  logic       vddOver,
  input  logic       vddUnderChkEn,
  input  logic       vddOverChkEn,
  output logic [1:0] ccTermEn,
  output logic [1:0] vconnEn,
  output logic       orientLow,
  output logic       pwrPathEn,
  output logic [1:0] attachMode,
  output logic [2:0] stateCode,
  output logic       debugFlag,
  output logic       detachPulse
);
  tcState_t  fsmState;
  dpStrobe_t dpStrobe;
  dpStatus_t dpStatus;

  typec_src_dpath #(
    .DEBOUNCE_TICKS(DEBOUNCE_TICKS),
    .RECOVERY_TICKS(RECOVERY_TICKS)
  ) u_dpath (
    .clk(clk), .rst(rst), .cc1Class(cc1Class), .cc2Class(cc2Class),
    .dpStrobe(dpStrobe), .dpStatus(dpStatus)
  );

  typec_src_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cc1Class(cc1Class), .cc2Class(cc2Class),
    .dpStatus(dpStatus), .vSafe0V(vSafe0V), .vbusPresent(vbusPresent),
    .vbusInRange(vbusInRange), .faultOverTemp(faultOverTemp),
    .faultPullupBad(faultPullupBad), .faultCcOvp(faultCcOvp),
    .vddUnder(vddUnder), .vddOver(vddOver), .vddUnderChkEn(vddUnderChkEn),
    .vddOverChkEn(vddOverChkEn), .state(fsmState), .orientLow(orientLow),
    .detachPulse(detachPulse), .dpStrobe(dpStrobe)
  );

  assign stateCode = fsmState;
  assign ccTermEn  = (rst || fsmState == ST_RECOVER) ? 2'b00 : 2'b11;
  assign vconnEn   = (fsmState == ST_ATT) ? (orientLow ? 2'b01 : 2'b10) : 2'b00;
  assign pwrPathEn = (fsmState == ST_ATT) || (fsmState == ST_DBG_UNOR) || (fsmState == ST_DBG_OR);
  assign debugFlag = (fsmState == ST_DBG_UNOR) || (fsmState == ST_DBG_OR);

  always_comb begin
    case (fsmState)
      ST_ATT:                attachMode = 2'd1;
      ST_AUDIO:              attachMode = 2'd2;
      ST_DBG_UNOR, ST_DBG_OR: attachMode = 2'd3;
      default:               attachMode = 2'd0;
    endcase
  end
endmodule

// File: rtl/typec_src_attach_chk.sv
module typec_src_attach_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] stateCode,
  input logic [1:0] attachMode,
  input logic       orientLow,
  input logic [1:0] vconnEn,
  input logic [1:0] ccTermEn,
  input logic       pwrPathEn,
  input logic       debugFlag,
  input logic       detachPulse,
  input logic       faultOverTemp,
  input logic       faultPullupBad,
  input logic       faultCcOvp
);
  // R1
  always_comb begin
    if (rst) reset_term_chk: assert (ccTermEn == 2'b00);
  end

  // R12
  recovery_term_chk: assert property (@(posedge clk) disable iff (rst)
    (stateCode == 3'd5) |-> (ccTermEn == 2'b00 && !pwrPathEn));

  // R12
  recovery_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (stateCode == 3'd5) |=> (stateCode == 3'd5 || stateCode == 3'd0));

  // R4
  vconn_side_chk: assert property (@(posedge clk) disable iff (rst)
    (vconnEn != 2'b00) |-> (stateCode == 3'd1 && vconnEn == (orientLow ? 2'b01 : 2'b10)));

  // R13
  pwr_state_chk: assert property (@(posedge clk) disable iff (rst)
    pwrPathEn |-> (stateCode == 3'd1 || stateCode == 3'd3 || stateCode == 3'd4));

  // R9
  detach_single_chk: assert property (@(posedge clk) disable iff (rst)
    detachPulse |=> !detachPulse);

  // R9
  detach_state_chk: assert property (@(posedge clk) disable iff (rst)
    detachPulse |-> (stateCode == 3'd0));

  // R10
  fault_entry_chk: assert property (@(posedge clk) disable iff (rst)
    ((faultOverTemp || faultPullupBad || faultCcOvp) && stateCode != 3'd5) |=> (stateCode == 3'd5));

  // R3
  orient_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stateCode == 3'd1) |=> (stateCode != 3'd1 || $stable(orientLow)));

  // R6
  debug_mode_chk: assert property (@(posedge clk) disable iff (rst)
    debugFlag |-> (attachMode == 2'd3));
endmodule

bind typec_src_attach typec_src_attach_chk u_chk (
  .clk(clk), .rst(rst), .stateCode(stateCode), .attachMode(attachMode),
  .orientLow(orientLow), .vconnEn(vconnEn), .ccTermEn(ccTermEn),
  .pwrPathEn(pwrPathEn), .debugFlag(debugFlag), .detachPulse(detachPulse),
  .faultOverTemp(faultOverTemp), .faultPullupBad(faultPullupBad),
  .faultCcOvp(faultCcOvp)
);

// File: tb/typec_src_attach_tb.sv
`timescale 1ns/1ps
module typec_src_attach_tb;
  localparam int DEB = 8;
  localparam int REC = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cc1Class = 2'd0, cc2Class = 2'd0;
  logic vSafe0V = 1'b0, vbusPresent = 1'b0, vbusInRange = 1'b1;
  logic faultOverTemp = 1'b0, faultPullupBad = 1'b0, faultCcOvp = 1'b0;
  logic vddUnder = 1'b0, vddOver = 1'b0, vddUnderChkEn = 1'b0, vddOverChkEn = 1'b0;
  logic [1:0] ccTermEn, vconnEn, attachMode;
  logic orientLow, pwrPathEn, debugFlag, detachPulse;
  logic [2:0] stateCode;

  always #2 clk = ~clk;

  typec_src_attach #(.DEBOUNCE_TICKS(DEB), .RECOVERY_TICKS(REC)) u_dut (
    .clk(clk), .rst(rst), .cc1Class(cc1Class), .cc2Class(cc2Class),
    .vSafe0V(vSafe0V), .vbusPresent(vbusPresent), .vbusInRange(vbusInRange),
    .faultOverTemp(faultOverTemp), .faultPullupBad(faultPullupBad),
    .faultCcOvp(faultCcOvp), .vddUnder(vddUnder), .vddOver(vddOver),
    .vddUnderChkEn(vddUnderChkEn), .vddOverChkEn(vddOverChkEn),
    .ccTermEn(ccTermEn), .vconnEn(vconnEn), .orientLow(orientLow),
    .pwrPathEn(pwrPathEn), .attachMode(attachMode), .stateCode(stateCode),
    .debugFlag(debugFlag), .detachPulse(detachPulse)
  );

  typedef struct packed {
    logic [2:0] st;
    logic [1:0] mode;
    logic       orient;
    logic [1:0] vconn;
    logic [1:0] term;
    logic       pwr;
    logic       dbg;
    logic       det;
  } obs_t;

  obs_t  expQ[$];
  string tagQ[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  // driver side: expected item derived from the requirements
  task automatic expect_obs(input string tag, input logic [2:0] st,
                            input logic orient, input logic det);
    obs_t e;
    e.st     = st;
    e.mode   = (st == 3'd1) ? 2'd1 : (st == 3'd2) ? 2'd2 :
               (st == 3'd3 || st == 3'd4) ? 2'd3 : 2'd0;
    e.orient = orient;
    e.vconn  = (st == 3'd1) ? (orient ? 2'b01 : 2'b10) : 2'b00;
    e.term   = (rst || st == 3'd5) ? 2'b00 : 2'b11;
    e.pwr    = (st == 3'd1 || st == 3'd3 || st == 3'd4);
    e.dbg    = (st == 3'd3 || st == 3'd4);
    e.det    = det;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0) begin
        obs_t e, a;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        a = {stateCode, attachMode, orientLow, vconnEn, ccTermEn, pwrPathEn, debugFlag, detachPulse};
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setCc(input logic [1:0] a, input logic [1:0] b);
    cc1Class = a;
    cc2Class = b;
  endtask

  initial begin
    cyc(2);
    expect_obs("R1 reset terms off", 3'd0, 1'b0, 1'b0);
    cyc(1);
    rst = 1'b0;
    cyc(1);
    expect_obs("R1 post-reset idle", 3'd0, 1'b0, 1'b0);
    vSafe0V = 1'b1;

    // R2 R3 R4 R7 R13: sink on CC1 with open CC2
    cyc(1); setCc(2'd2, 2'd0);
    cyc(DEB - 2); expect_obs("R7 before window", 3'd0, 1'b0, 1'b0);
    cyc(4);       expect_obs("R2 R3 R4 R13 attach CC1", 3'd1, 1'b0, 1'b0);
    // R9 detach
    setCc(2'd0, 2'd0);
    cyc(1); expect_obs("R9 detach pulse", 3'd0, 1'b0, 1'b1);
    cyc(1); expect_obs("R9 pulse one cycle", 3'd0, 1'b0, 1'b0);

    // R3 R4: sink on CC2 with Ra on CC1
    setCc(2'd1, 2'd2);
    cyc(DEB + 2); expect_obs("R3 R4 attach CC2", 3'd1, 1'b1, 1'b0);
    setCc(2'd1, 2'd0);
    cyc(1); expect_obs("R9 detach CC2", 3'd0, 1'b0, 1'b1);
    cyc(2);

    // R7: pattern glitch restarts the window
    setCc(2'd2, 2'd0); cyc(5);
    setCc(2'd0, 2'd0); cyc(2);
    setCc(2'd2, 2'd0);
    cyc(DEB - 2); expect_obs("R7 restarted window", 3'd0, 1'b0, 1'b0);
    cyc(4);       expect_obs("R7 attach after restart", 3'd1, 1'b0, 1'b0);
    setCc(2'd0, 2'd0); cyc(3);

    // R8: no attach without vSafe0V
    vSafe0V = 1'b0;
    setCc(2'd2, 2'd1);
    cyc(DEB + 4); expect_obs("R8 held off", 3'd0, 1'b0, 1'b0);
    vSafe0V = 1'b1;
    cyc(2); expect_obs("R8 attach once safe", 3'd1, 1'b0, 1'b0);
    setCc(2'd0, 2'd1); cyc(3);

    // R5: audio accessory, VBUS window fault ignored
    setCc(2'd1, 2'd1);
    cyc(DEB + 2); expect_obs("R5 audio", 3'd2, 1'b0, 1'b0);
    vbusPresent = 1'b1; vbusInRange = 1'b0;
    cyc(3); expect_obs("R5 R11 audio ignores window", 3'd2, 1'b0, 1'b0);
    vbusPresent = 1'b0; vbusInRange = 1'b1;
    setCc(2'd0, 2'd1);
    cyc(1); expect_obs("R9 audio detach", 3'd0, 1'b0, 1'b1);
    cyc(2);

    // R6: debug accessory, oriented on CC1 then on CC2
    setCc(2'd2, 2'd2);
    cyc(DEB + 2); expect_obs("R6 unoriented debug", 3'd3, 1'b0, 1'b0);
    setCc(2'd2, 2'd1);
    cyc(DEB + 2); expect_obs("R6 oriented debug CC1", 3'd4, 1'b0, 1'b0);
    setCc(2'd0, 2'd1);
    cyc(1); expect_obs("R9 debug detach", 3'd0, 1'b0, 1'b1);
    cyc(2);
    setCc(2'd2, 2'd2);
    cyc(DEB + 2); expect_obs("R6 unoriented again", 3'd3, 1'b0, 1'b0);
    setCc(2'd1, 2'd2);
    cyc(DEB + 2); expect_obs("R6 oriented debug CC2", 3'd4, 1'b1, 1'b0);
    setCc(2'd1, 2'd0);
    cyc(1); expect_obs("R9 debug CC2 detach", 3'd0, 1'b0, 1'b1);
    cyc(2);

    // R11 R12: VDD undervoltage masked, then enabled; full recovery hold
    setCc(2'd2, 2'd0);
    cyc(DEB + 2); expect_obs("R11 attach", 3'd1, 1'b0, 1'b0);
    vddUnder = 1'b1;
    cyc(3); expect_obs("R11 masked VDD flag", 3'd1, 1'b0, 1'b0);
    vddUnderChkEn = 1'b1;
    cyc(1); expect_obs("R11 R12 enter recovery", 3'd5, 1'b0, 1'b0);
    vddUnder = 1'b0; vddUnderChkEn = 1'b0;
    cyc(REC - 1); expect_obs("R12 last recovery cycle", 3'd5, 1'b0, 1'b0);
    cyc(1); expect_obs("R12 back to unattached", 3'd0, 1'b0, 1'b0);
    cyc(1); expect_obs("R12 reattach after hold", 3'd1, 1'b0, 1'b0);

    // R11: VBUS out of window while attached
    vbusPresent = 1'b1; vbusInRange = 1'b0;
    cyc(1); expect_obs("R11 window fault", 3'd5, 1'b0, 1'b0);
    vbusPresent = 1'b0; vbusInRange = 1'b1;
    setCc(2'd0, 2'd0);
    cyc(REC + 2); expect_obs("R12 recovered idle", 3'd0, 1'b0, 1'b0);

    // R11: VDD overvoltage enabled in debug state
    setCc(2'd2, 2'd2);
    cyc(DEB + 2);
    vddOver = 1'b1; vddOverChkEn = 1'b1;
    cyc(1); expect_obs("R11 VDD over in debug", 3'd5, 1'b0, 1'b0);
    vddOver = 1'b0; vddOverChkEn = 1'b0;
    setCc(2'd0, 2'd0);
    cyc(REC + 2);

    // R10: global faults from unattached and from attached
    faultCcOvp = 1'b1;
    cyc(1); expect_obs("R10 CC overvoltage idle", 3'd5, 1'b0, 1'b0);
    faultCcOvp = 1'b0;
    cyc(REC + 2);
    setCc(2'd0, 2'd2);
    cyc(DEB + 2); expect_obs("R10 attach before fault", 3'd1, 1'b1, 1'b0);
    faultOverTemp = 1'b1;
    cyc(1); expect_obs("R10 overtemp attached", 3'd5, 1'b0, 1'b0);
    faultOverTemp = 1'b0;
    setCc(2'd0, 2'd0);
    cyc(REC + 2);
    setCc(2'd1, 2'd1);
    cyc(DEB + 2);
    faultPullupBad = 1'b1;
    cyc(1); expect_obs("R10 pull-up bad in audio", 3'd5, 1'b0, 1'b0);
    faultPullupBad = 1'b0;
    cyc(3);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule